// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output Stage

This block is a first-in first-out buffer. Its write side and its read side run on two unrelated clocks. Words enter on port A and leave through a registered output stage on port B. Each port is qualified by four controls: an active-low chip select, a direction select, an active-high enable and an active-high mailbox select. On port B the direction select has the opposite sense to port A. Each data bus is tri-state. Port A drives back the last word it accepted when it is selected for reading. Port B drives its output register when it is selected for reading.

The write and read pointers are counters in Gray code. Each pointer passes through a chain of at least two flip-flops into the other clock domain. The input-ready flag is derived in the write domain and the data-available flag in the read domain. A static mode input chooses between two read behaviours. In standard mode the flag means the memory holds unread words, and only an explicit read moves a word into the output register. In fall-through mode a small state machine fills the output register by itself, and the flag means the output register holds a valid word.

Top module: `dcfifo_fwft`

## Requirements
- R1: A word is stored on a rising `wrClk` edge only when `aCsN`=0, `aWrRd`=1, `aEn`=1, `aMbx`=0 and `aInRdy`=1. If any one of these differs, nothing is stored.
- R2: `aInRdy` is 0 while the memory holds 2^ADDR_W words. A write attempted while it is 0 changes nothing.
- R3: `aData` is driven with the last stored word only while `aCsN`=0 and `aWrRd`=0. Otherwise it is high-impedance.
- R4: `bData` is driven with the output register only while `bCsN`=0 and `bWrRd`=1. Otherwise it is high-impedance.
- R5: A read is selected on a rising `rdClk` edge when `bCsN`=0, `bWrRd`=1, `bEn`=1, `bMbx`=0 and `bOutRdy`=1. With `bMbx`=1 no read takes place.
- R6: In standard mode (`fwftMode`=0), `bOutRdy` rises at the second rising `rdClk` edge after the write edge. The output register keeps its value until a read is selected, and that read loads the oldest unread word.
- R7: In fall-through mode (`fwftMode`=1), when `bOutRdy` is 0 a new word is loaded into the output register at the third rising `rdClk` edge after the write edge. `bOutRdy` rises on that same edge.
- R8: In fall-through mode a selected read consumes the output word. If another word is in memory, it is loaded on the same edge and `bOutRdy` stays 1. Otherwise `bOutRdy` falls.
- R9: While `bOutRdy`=0, read attempts are ignored and the output register holds the previous word.
- R10: Words leave in the order they were written, including after the pointers wrap past the end of the memory.
- R11: After reset, `aInRdy`=1, `bOutRdy`=0 and the output and echo registers are zero. `fwftMode` may only change while `rstN`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Port A clock |
| rdClk | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| fwftMode | input | 1 | 1 = fall-through mode, 0 = standard mode |
| aCsN | input | 1 | Port A chip select, active low |
| aWrRd | input | 1 | Port A direction: 1 = write, 0 = read back |
| aEn | input | 1 | Port A enable |
| aMbx | input | 1 | Port A mailbox select; 1 blocks FIFO access |
| aData | inout | DATA_W | Port A data: write input / echo output |
| aInRdy | output | 1 | Input-ready flag (not full) |
| bCsN | input | 1 | Port B chip select, active low |
| bWrRd | input | 1 | Port B direction: 1 = read, 0 = bus released |
| bEn | input | 1 | Port B enable |
| bMbx | input | 1 | Port B mailbox select; 1 blocks FIFO access |
| bData | output | DATA_W | Port B tri-state data output |
| bOutRdy | output | 1 | Empty flag (standard) / output-ready flag (fall-through) |

## Verification
The hardest cases to reach from the ports are the exact edge counts of the flag latency. The write edge and the read clock are unrelated, so the first read edge after a write can fall anywhere. The bench arms the write and then counts `rdClk` edges from the very edge that stored the word, using a forked release of the write controls so that no read edge is missed. A second hard case is the full condition with the pointer wrap behind it. It needs a burst of writes with no read activity, followed by two fill-and-drain rounds in fall-through mode that push the address past the end of the memory.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Strobes from the control block to the datapath
  typedef struct packed {
    logic wrPush;  // store port A word (wrClk domain)
    logic rdLoad;  // move memory word to output register (rdClk domain)
  } fifoStrobes_t;

  // Output-stage occupancy in fall-through mode
  typedef enum logic {
    OR_EMPTY   = 1'b0,
    OR_HOLDING = 1'b1
  } orState_e;

endpackage

// File: rtl/dcfifo_gsync.sv
module dcfifo_gsync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] r;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) r <= '0;
          else       r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) r <= '0;
          else       r <= g_stage[s-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              fwftMode,
  input  logic              aCsN,
  input  logic              aWrRd,
  input  logic              aEn,
  input  logic              aMbx,
  input  logic              bCsN,
  input  logic              bWrRd,
  input  logic              bEn,
  input  logic              bMbx,
  output logic              inRdy,
  output logic              outRdy,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, wrBinNext, rdGraySync, rdSyncBin, wrFill;
  logic          fullNow, wrPush;

  dcfifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) rdPtrSync_i (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync)
  );

  assign fullNow   = (wrGray == {~rdGraySync[PW-1:PW-2], rdGraySync[PW-3:0]});
  assign inRdy     = !fullNow;
  assign wrPush    = !aCsN && aWrRd && aEn && !aMbx && inRdy;
  assign wrBinNext = wrBin + PW'(1);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrPush) begin
      wrBin  <= wrBinNext;
      wrGray <= bin2gray(wrBinNext);
    end
  end

  assign rdSyncBin = gray2bin(rdGraySync);
  assign wrFill    = wrBin - rdSyncBin;

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!rstN)
    wrFill <= PW'(DEPTH)); // R2
  AST_FULL_FREEZES_WRPTR: assert property (@(posedge wrClk) disable iff (!rstN)
    !inRdy |=> $stable(wrBin)); // R2

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, rdBinNext, wrGraySync, wrSyncBin, rdFill;
  logic          memHasData, rdSel, rdLoad;
  orState_e      orState;

  dcfifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) wrPtrSync_i (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );

  assign memHasData = (wrGraySync != rdGray);
  assign outRdy     = fwftMode ? (orState == OR_HOLDING) : memHasData;
  assign rdSel      = !bCsN && bWrRd && bEn && !bMbx && outRdy;
  assign rdLoad     = fwftMode ? (memHasData && ((orState == OR_EMPTY) || rdSel))
                               : rdSel;
  assign rdBinNext  = rdBin + PW'(1);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdLoad) begin
      rdBin  <= rdBinNext;
      rdGray <= bin2gray(rdBinNext);
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          orState <= OR_EMPTY;
    else if (!fwftMode) orState <= OR_EMPTY;
    else if (rdLoad)    orState <= OR_HOLDING;
    else if (rdSel)     orState <= OR_EMPTY;
  end

  assign wrSyncBin = gray2bin(wrGraySync);
  assign rdFill    = wrSyncBin - rdBin;

  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!rstN)
    rdFill <= PW'(DEPTH)); // R10
  AST_STD_EMPTY_NO_LOAD: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && !outRdy) |-> !strobes.rdLoad); // R9
  AST_OR_RISE_LOADS: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && $rose(outRdy)) |-> $past(strobes.rdLoad)); // R7

  // ---------------- outputs ----------------
  assign strobes.wrPush = wrPush;
  assign strobes.rdLoad = rdLoad;
  assign wrAddr         = wrBin[ADDR_W-1:0];
  assign rdAddr         = rdBin[ADDR_W-1:0];

endmodule

// File: rtl/dcfifo_dpath.sv
module dcfifo_dpath
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] echoWord,
  output logic [DATA_W-1:0] outWord
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrPush) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)               echoWord <= '0;
    else if (strobes.wrPush) echoWord <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)               outWord <= '0;
    else if (strobes.rdLoad) outWord <= mem[rdAddr];
  end

endmodule

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft
  import dcfifo_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              fwftMode,
  input  logic              aCsN,
  input  logic              aWrRd,
  input  logic              aEn,
  input  logic              aMbx,
  inout  wire  [DATA_W-1:0] aData,
  output logic              aInRdy,
  input  logic              bCsN,
  input  logic              bWrRd,
  input  logic              bEn,
  input  logic              bMbx,
  output logic [DATA_W-1:0] bData,
  output logic              bOutRdy
);

  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [DATA_W-1:0] echoWord, outWord;

  dcfifo_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
    .aCsN(aCsN), .aWrRd(aWrRd), .aEn(aEn), .aMbx(aMbx),
    .bCsN(bCsN), .bWrRd(bWrRd), .bEn(bEn), .bMbx(bMbx),
    .inRdy(aInRdy), .outRdy(bOutRdy), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  dcfifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(aData),
    .echoWord(echoWord), .outWord(outWord)
  );

  assign aData = (!aCsN && !aWrRd) ? echoWord : 'z;
  assign bData = (!bCsN && bWrRd)  ? outWord  : 'z;

endmodule

// File: tb/dcfifo_fwft_tb.sv
module dcfifo_fwft_tb_top;

  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 16;
  localparam int DW        = 16;
  localparam int DEPTH     = 16;
  localparam logic [DW-1:0] HIZ = 'z;

  logic wrClk, rdClk, rstN, fwftMode;
  logic aCsN, aWrRd, aEn, aMbx, bCsN, bWrRd, bEn, bMbx;
  logic [DW-1:0] aDrv;
  wire  [DW-1:0] aData;
  wire  [DW-1:0] bData;
  wire  aInRdy, bOutRdy;

  int checks = 0;
  int fails  = 0;
  logic          flagSeen [1:3];
  logic [DW-1:0] dataSeen [1:3];

  assign aData = aWrRd ? aDrv : 'z;

  dcfifo_fwft dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
    .aCsN(aCsN), .aWrRd(aWrRd), .aEn(aEn), .aMbx(aMbx),
    .aData(aData), .aInRdy(aInRdy),
    .bCsN(bCsN), .bWrRd(bWrRd), .bEn(bEn), .bMbx(bMbx),
    .bData(bData), .bOutRdy(bOutRdy)
  );

  initial begin
    wrClk = 0;
    forever #(WR_PERIOD/2) wrClk = ~wrClk;
  end

  initial begin
    rdClk = 0;
    #2;
    forever begin
      rdClk = 1; #(RD_PERIOD/2);
      rdClk = 0; #(RD_PERIOD/2);
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic doReset(input logic mode);
    rstN = 0; fwftMode = mode;
    aCsN = 1; aWrRd = 1; aEn = 0; aMbx = 0; aDrv = '0;
    bCsN = 0; bWrRd = 1; bEn = 0; bMbx = 0;
    repeat (3) @(posedge rdClk);
    @(negedge wrClk); #1 rstN = 1;
    repeat (2) @(posedge rdClk);
    #1;
  endtask

  task automatic pushTry(input logic [DW-1:0] val, input logic cs, input logic wr,
                         input logic en, input logic mb);
    @(negedge wrClk);
    aCsN = cs; aWrRd = wr; aEn = en; aMbx = mb; aDrv = val;
    @(posedge wrClk); #2;
    aCsN = 1; aWrRd = 1; aEn = 0; aMbx = 0;
  endtask

  task automatic pushWord(input logic [DW-1:0] val);
    pushTry(val, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  // Write one word and trace flag/bus after each of the next three rdClk edges
  task automatic pushAndTrace(input logic [DW-1:0] val);
    @(negedge wrClk);
    aCsN = 0; aWrRd = 1; aEn = 1; aMbx = 0; aDrv = val;
    @(posedge wrClk);
    fork
      begin #2; aCsN = 1; aEn = 0; end
    join_none
    for (int e = 1; e <= 3; e++) begin
      @(posedge rdClk); #1;
      flagSeen[e] = bOutRdy;
      dataSeen[e] = bData;
    end
  endtask

  task automatic popTry(input logic mb);
    @(negedge rdClk);
    bEn = 1; bMbx = mb;
    @(posedge rdClk); #1;
    bEn = 0; bMbx = 0;
  endtask

  task automatic waitOutRdy();
    for (int n = 0; n < 40 && !bOutRdy; n++) begin
      @(posedge rdClk); #1;
    end
  endtask

  task automatic readEcho(output logic [DW-1:0] v);
    @(negedge wrClk);
    aWrRd = 0; aCsN = 0;
    #1 v = aData;
    aCsN = 1; aWrRd = 1;
  endtask

  // R11 reset state, R3/R4 bus release
  task automatic testReset();
    logic [DW-1:0] v;
    doReset(1'b0);
    check("R11 aInRdy after reset", {15'b0, aInRdy}, 16'd1);
    check("R11 bOutRdy after reset", {15'b0, bOutRdy}, 16'd0);
    check("R11 output register zero", bData, 16'h0000);
    bCsN = 1; #1;
    check("R4 bData released when bCsN=1", bData, HIZ);
    bCsN = 0; bWrRd = 0; #1;
    check("R4 bData released when bWrRd=0", bData, HIZ);
    bWrRd = 1;
    @(negedge wrClk); aWrRd = 0; aCsN = 1; #1;
    check("R3 aData released when aCsN=1", aData, HIZ);
    aWrRd = 1;
    readEcho(v);
    check("R11 echo register zero", v, 16'h0000);
  endtask

  // R1 write qualifiers
  task automatic testWriteGating();
    logic [DW-1:0] v;
    doReset(1'b0);
    pushTry(16'hDEAD, 1'b1, 1'b1, 1'b1, 1'b0);
    pushTry(16'hDEAD, 1'b0, 1'b0, 1'b1, 1'b0);
    pushTry(16'hDEAD, 1'b0, 1'b1, 1'b0, 1'b0);
    pushTry(16'hDEAD, 1'b0, 1'b1, 1'b1, 1'b1);
    repeat (6) @(posedge rdClk);
    #1;
    check("R1 no word stored by disqualified writes", {15'b0, bOutRdy}, 16'd0);
    readEcho(v);
    check("R1 echo unchanged by disqualified writes", v, 16'h0000);
    pushWord(16'h1234);
    readEcho(v);
    check("R3 echo shows last stored word", v, 16'h1234);
  endtask

  // R6 standard latency, R5 read qualifiers, R9 empty read
  task automatic testStandard();
    doReset(1'b0);
    pushAndTrace(16'hA5A5);
    check("R6 flag low after first rdClk edge", {15'b0, flagSeen[1]}, 16'd0);
    check("R6 flag high after second rdClk edge", {15'b0, flagSeen[2]}, 16'd1);
    check("R6 output register untouched without read", dataSeen[3], 16'h0000);
    popTry(1'b1);
    check("R5 mailbox select blocks read (data)", bData, 16'h0000);
    check("R5 mailbox select blocks read (flag)", {15'b0, bOutRdy}, 16'd1);
    popTry(1'b0);
    check("R5 selected read loads oldest word", bData, 16'hA5A5);
    check("R5 flag falls when memory drained", {15'b0, bOutRdy}, 16'd0);
    popTry(1'b0);
    check("R9 read while empty keeps previous word", bData, 16'hA5A5);
  endtask

  // R7 fall-through latency, R8 consumption, R9
  task automatic testFallThrough();
    doReset(1'b1);
    pushAndTrace(16'h0F0F);
    check("R7 OR low after edge 1", {15'b0, flagSeen[1]}, 16'd0);
    check("R7 OR low after edge 2", {15'b0, flagSeen[2]}, 16'd0);
    check("R7 output not yet loaded after edge 2", dataSeen[2], 16'h0000);
    check("R7 OR high after edge 3", {15'b0, flagSeen[3]}, 16'd1);
    check("R7 word loaded on edge 3", dataSeen[3], 16'h0F0F);
    pushWord(16'h1111);
    pushWord(16'h2222);
    repeat (4) @(posedge rdClk);
    #1;
    popTry(1'b0);
    check("R8 next word loaded on consuming read", bData, 16'h1111);
    check("R8 OR stays high with word pending", {15'b0, bOutRdy}, 16'd1);
    popTry(1'b0);
    check("R8 last word loaded", bData, 16'h2222);
    popTry(1'b0);
    check("R8 OR falls with nothing pending", {15'b0, bOutRdy}, 16'd0);
    check("R8 previous word held after drain", bData, 16'h2222);
    popTry(1'b0);
    check("R9 read while OR low ignored", bData, 16'h2222);
  endtask

  // R2 full behaviour, R10 ordering
  task automatic testFull();
    logic [DW-1:0] v;
    doReset(1'b0);
    for (int i = 0; i < DEPTH; i++) pushWord(16'h0100 + 16'(i));
    check("R2 input-ready low when full", {15'b0, aInRdy}, 16'd0);
    pushWord(16'hBEEF);
    readEcho(v);
    check("R2 write while full ignored", v, 16'h010F);
    for (int i = 0; i < DEPTH; i++) begin
      waitOutRdy();
      popTry(1'b0);
      check("R10 standard-mode order", bData, 16'h0100 + 16'(i));
    end
    check("R2 extra word absent after drain", {15'b0, bOutRdy}, 16'd0);
    repeat (4) @(posedge wrClk);
    #2;
    check("R2 input-ready returns after drain", {15'b0, aInRdy}, 16'd1);
  endtask

  // R10 pointer wrap in fall-through mode
  task automatic testWrap();
    doReset(1'b1);
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 12; i++) pushWord(16'h3000 + 16'(r * 64 + i));
      for (int i = 0; i < 12; i++) begin
        waitOutRdy();
        check("R10 fall-through order across wrap", bData, 16'h3000 + 16'(r * 64 + i));
        popTry(1'b0);
      end
    end
    check("R8 OR low after final drain", {15'b0, bOutRdy}, 16'd0);
  endtask

  initial begin
    #(WR_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    testReset();
    testWriteGating();
    testStandard();
    testFallThrough();
    testFull();
    testWrap();
    summary();
    $finish;
  end

endmodule